// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus Port

This block is a parameterised register, eight bits wide by default, with four modes chosen by two select inputs. It can keep its value, move every bit one place toward the high end, move every bit one place toward the low end, or take a whole new word from its parallel port. Select lines, serial inputs and parallel data are all sampled on the rising clock edge.

The parallel port is bidirectional. It reads the word in during a load, and it shows the stored word at other times. At the pad it is split into three signals: a drive-data vector, which always carries the register value, one combined drive-enable, and an input vector. The enable is high only when both active-low output enables are low and the block is not in load mode. Two serial outputs carry the lowest and highest bits, and they are driven at all times. This lets units be chained into longer registers. The high-end output of one unit feeds the low-end serial input of the next unit. The low-end output of the next unit feeds the high-end serial input of the one before it.

An active-low reset clears the register at once, without waiting for a clock. Release of reset is synchronised to the clock, so the register takes no edge until the release has passed through the synchroniser.

Top module: `shreg_universal`

## Requirements
- R1: While `rst_n` is low, the register reads zero on `pin_out` at once, without a clock edge, whatever the other inputs are.
- R2: After `rst_n` rises, the register keeps zero for SYNC_STAGES rising edges. The first edge that can change it is edge SYNC_STAGES+1.
- R3: With `sel_right`=0 and `sel_left`=0, the register keeps its value on every edge. Serial and parallel inputs have no effect.
- R4: With `sel_right`=1 and `sel_left`=0, bit n moves to bit n+1 on each edge, and `ser_in_lo` enters bit 0.
- R5: With `sel_right`=0 and `sel_left`=1, bit n moves to bit n-1 on each edge, and `ser_in_hi` enters bit WIDTH-1.
- R6: With both selects at 1, the register takes `pin_in` on one edge, whatever the output enables are.
- R7: `pin_oe` is 1 only when `oe_a_n`=0, `oe_b_n`=0, and the two selects are not both 1. `pin_out` always carries the register value.
- R8: `ser_out_lo` equals register bit 0 and `ser_out_hi` equals bit WIDTH-1 at all times, whatever the output enables are.
- R9: Two units chained through their serial pins work as one register twice as wide. Bits cross the boundary in both shift directions. Tying the last high-end output back to the first low-end input rotates the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_right | input | 1 | Mode select, low bit: shift toward the high end when it is the only select set |
| sel_left | input | 1 | Mode select, high bit: shift toward the low end when it is the only select set |
| oe_a_n | input | 1 | Active-low output enable, first |
| oe_b_n | input | 1 | Active-low output enable, second |
| ser_in_lo | input | 1 | Serial input into bit 0 during a shift toward the high end |
| ser_in_hi | input | 1 | Serial input into the top bit during a shift toward the low end |
| pin_in | input | WIDTH | Parallel port, input side |
| pin_out | output | WIDTH | Parallel port, drive data (register value) |
| pin_oe | output | 1 | Parallel port, combined drive enable |
| ser_out_lo | output | 1 | Register bit 0, always driven |
| ser_out_hi | output | 1 | Register top bit, always driven |

## Verification
Each register result is due one rising edge after the selects and data that cause it. The bench sets inputs on a falling edge and compares on the next falling edge, so every compare sits half a period after the edge that produced the result. The drive enable and the reset clear have no clock delay. The bench checks them 1 ns after changing the inputs or reset, while no edge occurs. After reset release, the bench expects zero on the first SYNC_STAGES edges and looks for the loaded word only after edge SYNC_STAGES+1.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  // Encoding is {sel_left, sel_right}
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shift_mode_e;
endpackage

// File: rtl/shreg_rst_sync.sv
module shreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic [STAGES:0]   chain_ext;

  assign chain_ext = {chain_q, 1'b1};

  always_comb begin
    chain_d = chain_ext[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

  AST_SYNC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n_o) |-> $past(rst_n)); // R2
endmodule

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
  import shreg_pkg::*;
(
  input  logic        sel_right_i,
  input  logic        sel_left_i,
  input  logic        oe_a_n_i,
  input  logic        oe_b_n_i,
  output shift_mode_e mode_o,
  output logic        drive_en_o
);
  always_comb begin
    mode_o     = shift_mode_e'({sel_left_i, sel_right_i});
    drive_en_o = ~oe_a_n_i & ~oe_b_n_i & (mode_o != MODE_LOAD);
  end
endmodule

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_mode_e      mode_i,
  input  logic [WIDTH-1:0] cur_i,
  input  logic             ser_lo_i,
  input  logic             ser_hi_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             upd_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b1;
    unique case (mode_i)
      MODE_RIGHT: nxt_o = {cur_i[MSB-1:0], ser_lo_i};
      MODE_LEFT:  nxt_o = {ser_hi_i, cur_i[MSB:1]};
      MODE_LOAD:  nxt_o = par_i;
      default:    upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shreg_universal.sv
module shreg_universal
  import shreg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_right,
  input  logic             sel_left,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int MSB = WIDTH - 1;

  logic             rst_int_n;
  shift_mode_e      mode;
  logic             drive_en;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;
  logic             data_en;

  shreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  shreg_mode_dec u_mode_dec (
    .sel_right_i (sel_right),
    .sel_left_i  (sel_left),
    .oe_a_n_i    (oe_a_n),
    .oe_b_n_i    (oe_b_n),
    .mode_o      (mode),
    .drive_en_o  (drive_en)
  );

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .mode_i   (mode),
    .cur_i    (data_q),
    .ser_lo_i (ser_in_lo),
    .ser_hi_i (ser_in_hi),
    .par_i    (pin_in),
    .nxt_o    (data_d),
    .upd_o    (data_en)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign pin_out    = data_q;
  assign pin_oe     = drive_en;
  assign ser_out_lo = data_q[0];
  assign ser_out_hi = data_q[MSB];

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (pin_out == '0); // R1
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sel_right && !sel_left) |=> (pin_out == $past(pin_out))); // R3

  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_right && !sel_left) |=> (pin_out == {$past(pin_out[MSB-1:0]), $past(ser_in_lo)})); // R4

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sel_right && sel_left) |=> (pin_out == {$past(ser_in_hi), $past(pin_out[MSB:1])})); // R5

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_right && sel_left) |=> (pin_out == $past(pin_in))); // R6

  AST_PORT_QUIET_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_right && sel_left) |-> !pin_oe); // R7

  AST_PORT_QUIET_OE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (oe_a_n || oe_b_n) |-> !pin_oe); // R7
endmodule

// File: tb/shreg_universal_test.sv
module shreg_universal_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SYNC       = 2;

  logic clk;
  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         rst_n, sel_r, sel_l, oe_a_n, oe_b_n, ext_lo, ext_hi, recirc;
  logic [W-1:0] in_a, in_b, out_a, out_b;
  logic         poe_a, poe_b, sa_lo, sa_hi, sb_lo, sb_hi, first_lo;

  assign first_lo = recirc ? sb_hi : ext_lo;

  shreg_universal #(.WIDTH(W), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .sel_right(sel_r), .sel_left(sel_l),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_in_lo(first_lo), .ser_in_hi(sb_lo),
    .pin_in(in_a), .pin_out(out_a), .pin_oe(poe_a),
    .ser_out_lo(sa_lo), .ser_out_hi(sa_hi)
  );

  shreg_universal #(.WIDTH(W), .SYNC_STAGES(SYNC)) uut_b (
    .clk(clk), .rst_n(rst_n), .sel_right(sel_r), .sel_left(sel_l),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .ser_in_lo(sa_hi), .ser_in_hi(ext_hi),
    .pin_in(in_b), .pin_out(out_b), .pin_oe(poe_b),
    .ser_out_lo(sb_lo), .ser_out_hi(sb_hi)
  );

  logic [2*W-1:0] model;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    @(negedge clk);
    chk(req, 32'({out_b, out_a}), 32'(model));
    chk("R8", 32'(sa_lo), 32'(model[0]));
    chk("R8", 32'(sa_hi), 32'(model[W-1]));
    chk("R8", 32'(sb_lo), 32'(model[W]));
    chk("R8", 32'(sb_hi), 32'(model[2*W-1]));
  endtask

  task automatic step(input logic r, input logic l, input string req);
    sel_r = r;
    sel_l = l;
    case ({l, r})
      2'b01:   model = {model[2*W-2:0], recirc ? model[2*W-1] : ext_lo};
      2'b10:   model = {ext_hi, model[2*W-1:1]};
      2'b11:   model = {in_b, in_a};
      default: ;
    endcase
    cyc(req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b1; sel_r = 1'b0; sel_l = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0;
    ext_lo = 1'b0; ext_hi = 1'b0; recirc = 1'b0; in_a = '0; in_b = '0; model = '0;
    #1;
    // R1: reset overrides a pending load
    rst_n = 1'b0; sel_r = 1'b1; sel_l = 1'b1; in_a = 8'hFF; in_b = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1", 32'({out_b, out_a}), 32'h0);
    chk("R7", 32'(poe_a), 32'h0);

    // R2: release passes through the synchroniser before the first capture
    rst_n = 1'b1; in_a = 8'hA5; in_b = 8'h5A;
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2", 32'({out_b, out_a}), 32'h0);
    end
    model = {in_b, in_a};
    cyc("R2");

    // R7 sweep over enables and selects; R6 load with enables high
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kb;
      kb = 4'(k);
      oe_a_n = kb[0]; oe_b_n = kb[1]; sel_r = kb[2]; sel_l = kb[3];
      #1;
      chk("R7", 32'(poe_a), 32'(!kb[0] && !kb[1] && !(kb[2] && kb[3])));
      chk("R7", 32'(poe_b), 32'(!kb[0] && !kb[1] && !(kb[2] && kb[3])));
      chk("R7", 32'({out_b, out_a}), 32'(model));
      step(kb[2], kb[3], "R9");
    end

    // R6 exhaustive load sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      in_a = vb; in_b = 8'(v * 37 + 11); oe_a_n = vb[0]; oe_b_n = vb[1];
      step(1'b1, 1'b1, "R6");
    end

    // R3 hold ignores serial and parallel inputs
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      ext_lo = i[0]; ext_hi = ~i[0]; in_a = 8'(i * 19); in_b = 8'(i * 7);
      step(1'b0, 1'b0, "R3");
    end

    // R4 shift toward the high end across the unit boundary
    oe_a_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ext_lo = ((i * 5 + 3) % 7) < 3;
      step(1'b1, 1'b0, "R4");
    end

    // R5 shift toward the low end across the unit boundary
    for (int i = 0; i < 40; i++) begin
      ext_hi = ((i * 3 + 1) % 5) < 2;
      step(1'b0, 1'b1, "R5");
    end

    // R9 recirculation of the 16-bit word
    in_a = 8'h31; in_b = 8'h8C;
    step(1'b1, 1'b1, "R6");
    recirc = 1'b1;
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, "R9");
    chk("R9", 32'({out_b, out_a}), 32'h8C31);
    recirc = 1'b0;

    // R1 asynchronous clear in the middle of a cycle
    sel_r = 1'b0; sel_l = 1'b0;
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R1", 32'({out_b, out_a}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    for (int i = 0; i <= SYNC; i++) cyc("R1");

    summary();
    $finish;
  end
endmodule